// File: doc/BRIEF.md
# Triggered Event Capture Memory

This block records particle-trigger events into a small on-chip store while an acquisition window is open. A crossing counter advances once per clock while acquisition is active and holds at zero while it is idle. On the first clock in which any of the per-channel trigger inputs goes high, the block writes one entry. The entry holds the crossing number of that clock and the full trigger pattern, one hit bit per channel. A no-trigger inhibit and a full store both block the write.

A readout controller drains the stored events, oldest first, through a valid/ready port. A slot is freed only when an event is taken from that port. The occupancy count and a full flag are plain status outputs. When the store is full, new triggers are dropped until readout has removed at least one entry.

The read port follows these rules. `rd_valid` is high whenever at least one event is stored. An event leaves the store on each clock in which both `rd_valid` and `rd_ready` are high. While `rd_valid` is high and `rd_ready` is low, the presented entry does not change. The readout side may hold `rd_ready` low for any length of time. Capture never waits on it; it only stops when the store is full.

Top module: `bx_event_builder`

## Requirements
- R1: After reset the store is empty: `evt_count` is 0, and `ram_full` and `rd_valid` are low.
- R2: The crossing number recorded for an event taken on the k-th consecutive clock with `acq_en` high (k counted from 1) is (k-1) modulo 2^BC_W. Every clock with `acq_en` low sets the count back to zero.
- R3: With `acq_en` high, a clock in which some `trig` bit is high and in which all `trig` bits were low on the previous clock stores one event. Bit i of the stored `rd_hits` equals bit i of `trig` in that clock.
- R4: A trigger pattern that stays non-zero over consecutive clocks stores only one event. Any number of channels high in the same clock also forms only one event. A further event requires a clock with all triggers low first.
- R5: A trigger rise in a clock with `no_trig` high stores nothing. A pattern that stays high after `no_trig` falls does not count as a new rise.
- R6: Triggers in clocks with `acq_en` low store nothing.
- R7: `evt_count` equals the number of stored events, from 0 to DEPTH (16 by default). `ram_full` is high exactly when `evt_count` equals DEPTH.
- R8: While `ram_full` is high, a trigger rise stores nothing, even in a clock in which an event is read out.
- R9: `rd_valid` is high whenever `evt_count` is non-zero. Events are presented in capture order. The presented entry is stable while `rd_ready` is low, and one event is removed on each clock with `rd_valid` and `rd_ready` both high.
- R10: A capture and a readout in the same clock leave `evt_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_en | input | 1 | Acquisition window; high runs the crossing counter and allows capture |
| no_trig | input | 1 | Capture inhibit |
| trig | input | CHANNELS (36) | Per-channel trigger inputs |
| evt_count | output | $clog2(DEPTH+1) (5) | Number of stored events |
| ram_full | output | 1 | Store has no free slot |
| rd_valid | output | 1 | An event is presented on the read port |
| rd_ready | input | 1 | Readout accepts the presented event |
| rd_bcid | output | BC_W (12) | Crossing number of the presented event |
| rd_hits | output | CHANNELS (36) | Hit pattern of the presented event |

## Verification
A corrupted read or write pointer shows on the read port as a reordered, repeated or stale entry. It is seen at the first readout that follows the corruption. A wrong occupancy count shows on `evt_count`, `ram_full` or `rd_valid` on the very next clock. The edge detector and the crossing counter have no status of their own; an error in either appears as a missing or extra event, or as a wrong `rd_bcid`, when that event reaches the head of the store. The reference model in the bench is compared against all read-port and status outputs on every clock. Each fault therefore surfaces no later than the clock in which the affected entry becomes visible.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int DEF_CHANNELS = 36;
  localparam int DEF_DEPTH    = 16;
  localparam int DEF_BC_W     = 12;

  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic bit is_pow2(input int value);
    return (value > 0) && ((value & (value - 1)) == 0);
  endfunction
endpackage

// File: rtl/evb_bc_counter.sv
module evb_bc_counter #(
  parameter int BC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acq_en,
  output logic [BC_W-1:0] bcid
);
  // Idle holds zero, so the first active clock carries crossing 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bcid <= '0;
    else if (!acq_en) bcid <= '0;
    else              bcid <= bcid + 1'b1;
  end
endmodule

// File: rtl/evb_trig_edge.sv
module evb_trig_edge #(
  parameter int CHANNELS = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] trig,
  input  logic                acq_en,
  input  logic                no_trig,
  input  logic                store_full,
  output logic                capture
);
  logic any_now;
  logic any_prev;

  assign any_now = |trig;

  // Previous-clock activity is tracked regardless of the gates, so a
  // pattern that outlives an inhibit or a full store is not a new rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_prev <= 1'b0;
    else        any_prev <= any_now;
  end

  assign capture = acq_en & ~no_trig & ~store_full & any_now & ~any_prev;
endmodule

// File: rtl/evb_store.sv
module evb_store #(
  parameter int W     = 48,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  import evb_pkg::*;
  localparam int AW = ptr_width(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] wr_nxt, rd_nxt;

  generate
    if (is_pow2(DEPTH)) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
      assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
      unique case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == DEPTH_C);
endmodule

// File: rtl/bx_event_builder.sv
module bx_event_builder #(
  parameter int CHANNELS = evb_pkg::DEF_CHANNELS,
  parameter int DEPTH    = evb_pkg::DEF_DEPTH,
  parameter int BC_W     = evb_pkg::DEF_BC_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acq_en,
  input  logic                no_trig,
  input  logic [CHANNELS-1:0] trig,
  output logic [CNT_W-1:0]    evt_count,
  output logic                ram_full,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [BC_W-1:0]     rd_bcid,
  output logic [CHANNELS-1:0] rd_hits
);
  localparam int ENTRY_W = BC_W + CHANNELS;

  logic [BC_W-1:0]    bcid;
  logic               capture;
  logic               pop;
  logic [ENTRY_W-1:0] rd_entry;

  evb_bc_counter #(.BC_W(BC_W)) u_bc (
    .clk    (clk),
    .rst_n  (rst_n),
    .acq_en (acq_en),
    .bcid   (bcid)
  );

  evb_trig_edge #(.CHANNELS(CHANNELS)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .acq_en     (acq_en),
    .no_trig    (no_trig),
    .store_full (ram_full),
    .capture    (capture)
  );

  assign rd_valid = (evt_count != '0);
  assign pop      = rd_valid & rd_ready;

  evb_store #(.W(ENTRY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (capture),
    .wr_data ({bcid, trig}),
    .rd_en   (pop),
    .rd_data (rd_entry),
    .count   (evt_count),
    .full    (ram_full)
  );

  assign rd_bcid = rd_entry[ENTRY_W-1:CHANNELS];
  assign rd_hits = rd_entry[CHANNELS-1:0];
endmodule

// File: rtl/bx_event_builder_chk.sv
module bx_event_builder_chk #(
  parameter int CHANNELS = 36,
  parameter int DEPTH    = 16,
  parameter int BC_W     = 12,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acq_en,
  input logic                no_trig,
  input logic [CHANNELS-1:0] trig,
  input logic [CNT_W-1:0]    evt_count,
  input logic                ram_full,
  input logic                rd_valid,
  input logic                rd_ready,
  input logic [BC_W-1:0]     rd_bcid,
  input logic [CHANNELS-1:0] rd_hits
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    evt_count <= DEPTH_C); // R7

  AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (evt_count != '0)); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_bcid) && $stable(rd_hits))); // R9

  AST_FULL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    ram_full |=> (evt_count <= DEPTH_C && evt_count >= $past(evt_count) - 1'b1 && !(evt_count > $past(evt_count)))); // R8

  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_en && !(rd_valid && rd_ready)) |=> (evt_count == $past(evt_count))); // R6

  AST_INHIBIT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (no_trig && !(rd_valid && rd_ready)) |=> (evt_count == $past(evt_count))); // R5

  AST_HELD_TRIG_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trig) && $past(|trig) && !(rd_valid && rd_ready)) |=> (evt_count == $past(evt_count))); // R4
endmodule

bind bx_event_builder bx_event_builder_chk #(
  .CHANNELS(CHANNELS), .DEPTH(DEPTH), .BC_W(BC_W)
) u_chk (.*);

// File: tb/bx_event_builder_test.sv
module bx_event_builder_test;
  localparam int CH    = 36;
  localparam int DEPTH = 16;
  localparam int BC_W  = 12;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int EW    = BC_W + CH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acq_en = 1'b0;
  logic             no_trig = 1'b0;
  logic [CH-1:0]    trig = '0;
  logic             rd_ready = 1'b0;
  logic [CNT_W-1:0] evt_count;
  logic             ram_full, rd_valid;
  logic [BC_W-1:0]  rd_bcid;
  logic [CH-1:0]    rd_hits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bx_event_builder uut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .no_trig(no_trig), .trig(trig),
    .evt_count(evt_count), .ram_full(ram_full), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_bcid(rd_bcid), .rd_hits(rd_hits)
  );

  always #5 clk = ~clk;

  // Behavioural reference: a queue of {crossing, pattern} entries.
  logic [EW-1:0] mq[$];
  int  m_bc = 0;
  bit  m_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_bc = 0;
      m_prev = 1'b0;
    end else begin
      bit do_pop, do_cap;
      do_pop = (mq.size() > 0) && rd_ready;
      do_cap = acq_en && !no_trig && (trig != '0) && !m_prev && (mq.size() < DEPTH);
      if (do_pop) void'(mq.pop_front());
      if (do_cap) mq.push_back({BC_W'(m_bc), trig});
      m_prev = (trig != '0);
      m_bc   = acq_en ? (m_bc + 1) % (1 << BC_W) : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(evt_count == CNT_W'(mq.size()), "R7 count", evt_count, mq.size());
      chk(ram_full == (mq.size() == DEPTH), "R7 full", ram_full, mq.size() == DEPTH);
      chk(rd_valid == (mq.size() > 0), "R9 valid", rd_valid, mq.size() > 0);
      if (mq.size() > 0)
        chk({rd_bcid, rd_hits} == mq[0], "R3 head entry", {rd_bcid, rd_hits}, mq[0]);
    end
  end

  task automatic cyc(input bit a, input bit inh, input logic [CH-1:0] t, input bit rdy);
    acq_en = a; no_trig = inh; trig = t; rd_ready = rdy;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [CH-1:0] PA = 36'h8_0000_0001;
  localparam logic [CH-1:0] PB = 36'h0_F0F0_F0F0;
  localparam logic [CH-1:0] PC = 36'h0_0000_0100;
  localparam logic [CH-1:0] PD = 36'h5_5555_5555;
  localparam logic [CH-1:0] PE = 36'hF_FFFF_FFFF;

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(evt_count == 0 && !ram_full && !rd_valid, "R1 reset state",
        {evt_count, ram_full, rd_valid}, 0);
    rst_n = 1'b1;
    cyc(0, 0, '0, 0);
    chk(evt_count == 0 && !rd_valid, "R1 after release", evt_count, 0);

    // R2 / R3: four quiet active clocks, rise on the fifth -> crossing 4.
    for (int i = 0; i < 4; i++) cyc(1, 0, '0, 0);
    cyc(1, 0, PA, 0);
    chk(rd_valid && rd_bcid == 4, "R2 first crossing", rd_bcid, 4);
    chk(rd_hits == PA, "R3 pattern stored", rd_hits, PA);

    // R4: held and multi-bit patterns give one event each.
    cyc(1, 0, PA, 0);
    cyc(1, 0, '0, 0);
    cyc(1, 0, PB, 0);
    cyc(1, 0, PB, 0);
    cyc(1, 0, PB, 0);
    chk(evt_count == 2, "R4 held trigger one event", evt_count, 2);

    // R5: rise under inhibit, held after release, stores nothing.
    cyc(1, 0, '0, 0);
    cyc(1, 1, PC, 0);
    cyc(1, 0, PC, 0);
    cyc(1, 0, '0, 0);
    chk(evt_count == 2, "R5 inhibit", evt_count, 2);

    // R6: idle triggers ignored; R2: restart gives crossing 0.
    cyc(0, 0, PD, 0);
    cyc(0, 0, '0, 0);
    chk(evt_count == 2, "R6 idle trigger", evt_count, 2);
    cyc(1, 0, PD, 0);
    chk(evt_count == 3, "R2 restart capture", evt_count, 3);

    // R9: stable hold, then ordered drain.
    cyc(1, 0, '0, 0);
    chk(rd_bcid == 4 && rd_hits == PA, "R9 held head", rd_bcid, 4);
    cyc(0, 0, '0, 1);
    chk(rd_hits == PB, "R9 second in order", rd_hits, PB);
    cyc(0, 0, '0, 1);
    chk(rd_hits == PD && rd_bcid == 0, "R9 third in order", rd_bcid, 0);
    cyc(0, 0, '0, 1);
    chk(!rd_valid && evt_count == 0, "R9 drained", evt_count, 0);

    // R7 / R8: fill, then rises are dropped even with a pop.
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, 0, PE, 0);
      cyc(1, 0, '0, 0);
    end
    chk(ram_full && evt_count == DEPTH, "R7 full at depth", evt_count, DEPTH);
    cyc(1, 0, PB, 0);
    cyc(1, 0, '0, 0);
    chk(evt_count == DEPTH && rd_hits == PE, "R8 full drops", evt_count, DEPTH);
    cyc(1, 0, PB, 1);
    chk(evt_count == DEPTH - 1, "R8 full drops with pop", evt_count, DEPTH - 1);
    cyc(1, 0, '0, 0);
    cyc(1, 0, PC, 1);
    chk(evt_count == DEPTH - 1, "R10 capture plus pop", evt_count, DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, '0, 1);
    chk(evt_count == 0, "R9 empty after drain", evt_count, 0);

    // R2: counter wraps modulo 2^BC_W.
    cyc(0, 0, '0, 0);
    for (int i = 0; i < (1 << BC_W); i++) cyc(1, 0, '0, 0);
    cyc(1, 0, PA, 0);
    chk(rd_bcid == 0, "R2 wrap to zero", rd_bcid, 0);
    cyc(1, 0, '0, 1);
    cyc(1, 0, PC, 0);
    chk(rd_bcid == 2 && rd_hits == PC, "R2 after wrap", rd_bcid, 2);
    cyc(0, 0, '0, 1);
    cyc(0, 0, '0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule